// File: doc/BRIEF.md
# Phase-Accumulating Quadrature Oscillator with Zero-Word Preset

This block is a numerically controlled oscillator. A 32-bit frequency word is captured in a register, and each accepted sample adds that word to a 32-bit phase accumulator. The accumulator's upper bits drive a folded quarter-wave amplitude table, which produces a sine sample and a cosine sample in quadrature. Both are 12-bit two's complement values.

A frequency word of all zeros does more than stop the accumulator. It forces the accumulator to zero phase, so the outputs settle at sine 0 and cosine +2047. An external clear input has the same effect. A clock-health supervisor drives this input while the clock it watches is not yet trustworthy.

The output is a stream. `valid_o` follows `en_i`. A sample is consumed on a clock edge where both `valid_o` and `ready_i` are high, and the accumulator advances only on that edge. While `valid_o` is high and `ready_i` is low, the presented sample holds still. Two events override back-pressure: the clear input and a zero frequency word. Both reset the phase even while the sample is stalled.

Top module: `nco_zero_preset`

## Requirements
- R1: `ftw_i` is registered. A word presented before clock edge k is first added to the accumulator at edge k+1.
- R2: On an edge with `en_i` and `ready_i` high, `clr_i` low and a non-zero registered word, the accumulator (`phase_o`) becomes its old value plus the registered word, modulo 2^32.
- R3: If `en_i` or `ready_i` is low on an edge, and neither R4 nor R5 applies, `phase_o` keeps its value.
- R4: On an edge where the registered word equals 32'h00000000, `phase_o` becomes 0. This holds whatever the state of `en_i` and `ready_i`.
- R5: On an edge where `clr_i` is high, `phase_o` becomes 0. This takes precedence over every other condition.
- R6: Whenever `phase_o` is 0, `sin_o` is 0 and `cos_o` is +2047.
- R7: Only `phase_o[31:22]` sets the amplitude. Bits [31:30] give the quadrant (0 rising, 1 falling, 2 falling negative, 3 rising negative) and bits [29:22] give the table step. `sin_o` is within 5 LSB of 2047·sin(2π·p/1024), where p = `phase_o[31:22]`, and `cos_o` is within 5 LSB of 2047·cos(2π·p/1024). At p = 0, 256, 512 and 768 the values are exact.
- R8: `sin_o` and `cos_o` stay within −2047…+2047. The value −2048 is never produced.
- R9: `valid_o` equals `en_i`. While `valid_o` is high and `ready_i` is low, `sin_o`, `cos_o` and `phase_o` stay stable unless R4 or R5 applies.
- R10: After reset the registered word and the accumulator are zero, so the outputs read phase 0, sine 0 and cosine +2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ftw_i | input | 32 | Frequency tuning word |
| en_i | input | 1 | Enable; drives the output valid |
| clr_i | input | 1 | Phase clear from the clock-health supervisor |
| ready_i | input | 1 | Downstream accepts the current sample |
| valid_o | output | 1 | Sample stream valid |
| phase_o | output | 32 | Accumulator phase word |
| sin_o | output | 12 | Signed sine sample |
| cos_o | output | 12 | Signed cosine sample |

## Verification
The hardest case is a zero word or a clear that arrives while the stream is stalled. In that case the phase must collapse to zero even though no sample has been consumed, which breaks the usual hold rule. The stimulus first runs the accumulator to a non-zero phase under a repeating ready pattern. It then holds `ready_i` low and loads the zero word, and the stimulus checks that the phase holds for one edge and reaches zero on the next. Amplitude coverage comes from a step of 2^22, which visits every one of the 1024 table phases in turn.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // Quadrant order follows the two top phase bits; the fold logic relies on it.
  typedef enum logic [1:0] {
    Q_RISE     = 2'd0,
    Q_FALL     = 2'd1,
    Q_NEG_FALL = 2'd2,
    Q_NEG_RISE = 2'd3
  } quad_e;
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] ftw_i,
  input  logic               step_i,
  input  logic               clr_i,
  output logic [PHASE_W-1:0] acc_o,
  output logic               zero_word_o
);
  logic [PHASE_W-1:0] ftw_q;
  logic [PHASE_W-1:0] acc_q;

  assign zero_word_o = (ftw_q == '0);
  assign acc_o       = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw_q <= '0;
      acc_q <= '0;
    end else begin
      ftw_q <= ftw_i;
      if (clr_i || zero_word_o) acc_q <= '0;
      else if (step_i)          acc_q <= acc_q + ftw_q;
    end
  end

  // R4
  zero_word_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_word_o |=> (acc_q == '0));

  // R5
  clear_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_q == '0));

  // R2
  phase_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && !zero_word_o) |=> (acc_q == $past(acc_q) + $past(ftw_q)));

  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clr_i && !zero_word_o) |=> $stable(acc_q));
endmodule

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned MAG_W = 11
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [MAG_W-1:0] mag_o
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  typedef logic [ENTRIES-1:0][MAG_W-1:0] tab_t;

  // Rational quarter-sine fit, exact at both ends of the quarter.
  function automatic tab_t build_tab();
    tab_t   t;
    longint quarter, half, fs, p, num, den;
    quarter = longint'(ENTRIES);
    half    = 2 * quarter;
    fs      = (longint'(1) << MAG_W) - 1;
    for (int k = 0; k < int'(ENTRIES); k++) begin
      p    = longint'(k) * (half - longint'(k));
      den  = 5 * half * half - 4 * p;
      num  = 16 * fs * p;
      t[k] = MAG_W'((2 * num + den) / (2 * den));
    end
    return t;
  endfunction

  localparam tab_t TAB = build_tab();

  assign mag_o = TAB[idx_i];
endmodule

// File: rtl/nco_fold.sv
module nco_fold
  import nco_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned OUT_W = 12
) (
  input  quad_e                    quad_i,
  input  logic [IDX_W-1:0]         idx_i,
  output logic signed [OUT_W-1:0]  sample_o
);
  localparam int unsigned MAG_W = OUT_W - 1;
  localparam logic [MAG_W-1:0] FULL = '1;

  logic             mirror, negate, peak_sel;
  logic [IDX_W-1:0] rom_idx;
  logic [MAG_W-1:0] rom_mag, mag;
  logic signed [OUT_W-1:0] pos;

  assign mirror   = quad_i[0];
  assign negate   = quad_i[1];
  // The mirrored address of step 0 is the quarter peak, one past the table.
  assign peak_sel = mirror && (idx_i == '0);
  assign rom_idx  = mirror ? (~idx_i + IDX_W'(1)) : idx_i;

  nco_quarter_rom #(.IDX_W(IDX_W), .MAG_W(MAG_W)) u_rom (
    .idx_i (rom_idx),
    .mag_o (rom_mag)
  );

  assign mag      = peak_sel ? FULL : rom_mag;
  assign pos      = {1'b0, mag};
  assign sample_o = negate ? -pos : pos;
endmodule

// File: rtl/nco_zero_preset.sv
module nco_zero_preset
  import nco_pkg::*;
#(
  parameter int unsigned PHASE_W = 32,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned OUT_W   = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PHASE_W-1:0]       ftw_i,
  input  logic                     en_i,
  input  logic                     clr_i,
  input  logic                     ready_i,
  output logic                     valid_o,
  output logic [PHASE_W-1:0]       phase_o,
  output logic signed [OUT_W-1:0]  sin_o,
  output logic signed [OUT_W-1:0]  cos_o
);
  localparam int unsigned QUAD_LSB = PHASE_W - 2;
  localparam int unsigned IDX_LSB  = QUAD_LSB - IDX_W;
  localparam logic signed [OUT_W-1:0] POS_FS = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

  logic                    step, zero_word;
  logic [PHASE_W-1:0]      acc;
  logic signed [OUT_W-1:0] samples [2];

  assign valid_o = en_i;
  assign step    = en_i && ready_i;

  nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .ftw_i       (ftw_i),
    .step_i      (step),
    .clr_i       (clr_i),
    .acc_o       (acc),
    .zero_word_o (zero_word)
  );

  // Channel 0 is sine; channel 1 is cosine, a quarter turn ahead.
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    quad_e quad;
    assign quad = quad_e'(acc[PHASE_W-1 -: 2] + 2'(ch));
    nco_fold #(.IDX_W(IDX_W), .OUT_W(OUT_W)) u_fold (
      .quad_i   (quad),
      .idx_i    (acc[IDX_LSB +: IDX_W]),
      .sample_o (samples[ch])
    );
  end

  assign phase_o = acc;
  assign sin_o   = samples[0];
  assign cos_o   = samples[1];

  // R6
  zero_phase_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == '0) |-> (sin_o == '0 && cos_o == POS_FS));

  // R8
  no_neg_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sin_o != NEG_MAX) && (cos_o != NEG_MAX));

  // R9
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !clr_i && !zero_word) |=>
      ($stable(sin_o) && $stable(cos_o) && $stable(phase_o)));
endmodule

// File: tb/tb_nco_zero_preset.sv
module tb_nco_zero_preset;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ftw = '0;
  logic        en = 1'b0, clr = 1'b0, ready = 1'b0;
  logic        valid;
  logic [31:0] phase;
  logic signed [11:0] sin_s, cos_s;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_acc = '0, m_ftw = '0;
  logic [31:0] prev_ftw = '0;
  logic signed [11:0] prev_sin = '0, prev_cos = '0;
  logic prev_stall = 1'b0;
  string tag = "R10";

  always #2.5 clk = ~clk;

  nco_zero_preset dut (
    .clk(clk), .rst_n(rst_n), .ftw_i(ftw), .en_i(en), .clr_i(clr),
    .ready_i(ready), .valid_o(valid), .phase_o(phase), .sin_o(sin_s), .cos_o(cos_s)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  task automatic check_outputs();
    int  p, es, ec;
    real ang;
    p   = int'(m_acc[31:22]);
    ang = 2.0 * 3.14159265358979 * real'(p) / 1024.0;
    es  = rnd(2047.0 * $sin(ang));
    ec  = rnd(2047.0 * $cos(ang));
    chk(phase == m_acc, tag, "phase", phase, m_acc);
    chk(valid == en, "R9", "valid", valid, en);
    if (p % 256 == 0) begin
      chk(int'(sin_s) == es && int'(cos_s) == ec, "R7", "quadrant point sin*4096+cos",
          int'(sin_s) * 4096 + int'(cos_s), es * 4096 + ec);
    end else begin
      chk(int'(sin_s) - es <= 5 && es - int'(sin_s) <= 5, "R7", "sin", sin_s, es);
      chk(int'(cos_s) - ec <= 5 && ec - int'(cos_s) <= 5, "R7", "cos", cos_s, ec);
    end
    chk(sin_s != -12'sd2048 && cos_s != -12'sd2048, "R8", "neg max sin", sin_s, -2047);
    if (m_acc == '0)
      chk(sin_s == 0 && cos_s == 2047, "R6", "zero phase cos", cos_s, 2047);
  endtask

  task automatic tick();
    logic [31:0] nxt;
    prev_stall = en && !ready && !clr && (m_ftw != 0);
    prev_sin   = sin_s;
    prev_cos   = cos_s;
    @(posedge clk);
    if (!rst_n) begin
      nxt = '0; m_ftw = '0;
    end else begin
      if (clr || m_ftw == 0) nxt = '0;
      else if (en && ready)  nxt = m_acc + m_ftw;
      else                   nxt = m_acc;
      m_ftw = ftw;
    end
    m_acc = nxt;
    #1;
    check_outputs();
    if (prev_stall)
      chk(sin_s == prev_sin && cos_s == prev_cos, "R9", "stalled sin", sin_s, prev_sin);
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    // R10: reset state
    repeat (3) tick();
    #1 rst_n = 1'b1;
    tag = "R10";
    tick();
    chk(phase == 0 && sin_s == 0 && cos_s == 2047, "R10", "reset cos", cos_s, 2047);

    // R4: zero word keeps phase at zero even with enable and ready
    tag = "R4"; en = 1'b1; ready = 1'b1;
    repeat (4) tick();

    // R7: step of one table phase per sample visits all 1024 phases
    tag = "R7"; ftw = 32'h0040_0000;
    repeat (1030) tick();

    // R1: new word applied one edge after capture
    tag = "R1"; held = m_acc; ftw = 32'h0100_0000;
    tick();
    chk(phase == held + 32'h0040_0000, "R1", "old word still used", phase, held + 32'h0040_0000);
    tick();
    chk(phase == held + 32'h0140_0000, "R1", "new word used", phase, held + 32'h0140_0000);

    // R2: wrap modulo 2^32 with large words
    tag = "R2"; ftw = 32'hFFFF_FFFF;
    repeat (40) tick();
    ftw = 32'h9E37_79B9;
    repeat (300) tick();

    // R3: hold under back-pressure and disable
    tag = "R3";
    for (int i = 0; i < 200; i++) begin
      ready = (i % 3 == 0);
      en    = (i % 7 != 5);
      tick();
    end

    // R4: zero word arriving during a stall
    tag = "R4"; en = 1'b1; ready = 1'b0; held = m_acc; ftw = 32'h0;
    tick();
    chk(phase == held, "R4", "stalled before preset", phase, held);
    tick();
    chk(phase == 0 && sin_s == 0 && cos_s == 2047, "R4", "preset phase", phase, 0);
    ready = 1'b1; repeat (3) tick();

    // R5: clear overrides advance and disable
    tag = "R5"; ftw = 32'h1234_5678;
    repeat (20) tick();
    clr = 1'b1; tick();
    chk(phase == 0, "R5", "clear phase", phase, 0);
    clr = 1'b0; repeat (10) tick();
    en = 1'b0; clr = 1'b1; tick();
    chk(phase == 0 && cos_s == 2047, "R5", "clear while disabled", phase, 0);
    clr = 1'b0; en = 1'b1; repeat (10) tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule